// File: doc/BRIEF.md
# Button, Frame-Blank and Interrupt Vector Unit

This unit watches three active-low push-button inputs and an internally generated frame-blank tick. It keeps the current button levels in an input-level register and records what happened last in a change register. Every button edge and every blank tick raises a shared pointing/blank bit in an 8-bit interrupt vector. Three single-cycle event inputs from neighbouring receive and transmit logic set their own vector bits. An interrupt request output is high whenever the vector is non-zero.

The host reaches the unit over a simple byte bus with one-cycle read and write strobes and a 6-bit offset. Reading the change register is how the host acknowledges an interrupt: the read hands back the register's value, then drops the pending vector and the input-change status bit. A small output latch with separate OR-in and clear-out write offsets drives eight output pins in inverted form.

Top module: `inport_irq`

## Requirements
- R1: After reset the change register (read offset 0x13) is 0x40, the input-level register (read offset 0x37) is 0x0B, the status register (read offset 0x17) is 0x00, the vector is 0x00, irq_o is low and the output pins are 0xFF.
- R2: A press (input going low after the two-flop synchroniser) of button 0, 1 or 2 clears the change register to zero, then sets bit 7, bit 5 or bit 4 of it. It also sets input-level bits 3, 1 and 0 and then clears bit 3, bit 1 or bit 0 for the pressed button.
- R3: A release of a button clears the change register and then sets the same change bit as its press. It leaves input-level bits 3, 1 and 0 all set.
- R4: Every button press or release sets status bit 7 and vector bit 1 (value 0x02).
- R5: A blank tick fires once every TICK_DIV clock cycles. It sets change bit 6 without clearing the other change bits, sets status bit 7 and vector bit 1, and clears input-level bit 2.
- R6: A read of offset 0x13 returns the change register. It then clears change bits 3..0, status bit 7 and the whole vector. Change bits 7..4 keep their values.
- R7: A pulse on evt_kb_rx sets vector bit 2 (0x04), a pulse on evt_ser_tx sets bit 4 (0x10), and a pulse on evt_ser_rx sets bit 5 (0x20). These bits stay set until a read of offset 0x13.
- R8: A write to offset 0x3B ORs the data into the output latch. A write to offset 0x3F clears the latch bits that are 1 in the data. out_pins is the complement of the latch. Writes to any other offset leave the latch and the change register unchanged.
- R9: Read data appears on bus_rdata in the cycle after the read strobe. Reads of offsets other than 0x13, 0x17 and 0x37 return 0x00.
- R10: If an event arrives in the same cycle as a read of offset 0x13, the read returns the old value and the event's effect survives the clear.
- R11: If several buttons change in the same cycle, only the lowest-numbered one's event is applied to the change and input-level registers.
- R12: irq_o is high exactly when irq_vec is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_n_i | input | 3 | Raw active-low button inputs |
| evt_kb_rx | input | 1 | Keyboard-receive event pulse |
| evt_ser_tx | input | 1 | Serial-transmit event pulse |
| evt_ser_rx | input | 1 | Serial-receive event pulse |
| bus_addr | input | 6 | Register offset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| out_pins | output | 8 | Inverted output latch |
| irq_vec | output | 8 | Pending interrupt vector |
| irq_o | output | 1 | Interrupt request, vector non-zero |

## Verification
The bench goes after the mapping from each button to its change bit and input-level bit. A swapped index shows up as the wrong byte on a read of 0x13 or 0x37. It reads the change register twice in a row after a button event and after a tick. A design that cleared the whole register, or kept the low nibble and the vector, would return 0x00 or leave irq_o high. It lands an event pulse in the same cycle as the acknowledging read and presses two buttons at once. A design that let the clear win or applied the wrong button would lose the vector bit or report the wrong change bit. It also times the interval between two blank ticks, which catches an off-by-one in the divider.

// File: rtl/inport_pkg.sv
package inport_pkg;
  localparam int DW = 8;
  localparam int AW = 6;
  localparam int NBTN = 3;

  localparam logic [AW-1:0] OFS_CHG  = 6'h13;
  localparam logic [AW-1:0] OFS_STAT = 6'h17;
  localparam logic [AW-1:0] OFS_LVL  = 6'h37;
  localparam logic [AW-1:0] OFS_SET  = 6'h3B;
  localparam logic [AW-1:0] OFS_CLR  = 6'h3F;

  localparam logic [DW-1:0] CHG_RST  = 8'h40;
  localparam logic [DW-1:0] LVL_RST  = 8'h0B;
  localparam logic [DW-1:0] LVL_BTNS = 8'h0B;

  localparam int VEC_PTR   = 1;
  localparam int VEC_KB    = 2;
  localparam int VEC_STX   = 4;
  localparam int VEC_SRX   = 5;
  localparam int STAT_CHG  = 7;
  localparam int CHG_BLANK = 6;
  localparam int LVL_BLANK = 2;

  function automatic int chg_bit(input int b);
    case (b)
      0: chg_bit = 7;
      1: chg_bit = 5;
      default: chg_bit = 4;
    endcase
  endfunction

  function automatic int lvl_bit(input int b);
    case (b)
      0: lvl_bit = 3;
      1: lvl_bit = 1;
      default: lvl_bit = 0;
    endcase
  endfunction
endpackage

// File: rtl/inport_sync.sv
module inport_sync #(
  parameter int N = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] btn_n_i,
  output logic [N-1:0] press_o,
  output logic [N-1:0] release_o
);
  localparam int MSB = STAGES - 1;

  for (genvar g = 0; g < N; g++) begin : g_btn
    logic [STAGES-1:0] sh;
    logic              prev;
    always_ff @(posedge clk) begin
      if (rst) begin
        sh   <= '1;
        prev <= 1'b1;
      end else begin
        sh   <= {sh[STAGES-2:0], btn_n_i[g]};
        prev <= sh[MSB];
      end
    end
    assign press_o[g]   = prev & ~sh[MSB];
    assign release_o[g] = ~prev & sh[MSB];
  end
endmodule

// File: rtl/blank_tick_gen.sv
module blank_tick_gen #(
  parameter int DIV = 833_333
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= (cnt == LAST);
      cnt    <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/outport_latch.sv
module outport_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] pins_o
);
  logic [W-1:0] latch_q, latch_n;

  always_comb begin
    latch_n = latch_q;
    if (set_we) latch_n = latch_n | wdata;
    if (clr_we) latch_n = latch_n & ~wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      pins_o  <= '1;
    end else begin
      latch_q <= latch_n;
      pins_o  <= ~latch_n;
    end
  end
endmodule

// File: rtl/inport_irq.sv
module inport_irq
  import inport_pkg::*;
#(
  parameter int TICK_DIV = 833_333,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NBTN-1:0] btn_n_i,
  input  logic          evt_kb_rx,
  input  logic          evt_ser_tx,
  input  logic          evt_ser_rx,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [DW-1:0] out_pins,
  output logic [DW-1:0] irq_vec,
  output logic          irq_o
);
  logic [NBTN-1:0] press, rel;
  logic            tick;
  logic            ev_any;
  logic            rd_chg;
  logic [DW-1:0]   chg_q, lvl_q, stat_q;
  logic [DW-1:0]   chg_n, lvl_n, stat_n, vec_n;

  inport_sync #(.N(NBTN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .btn_n_i(btn_n_i),
    .press_o(press), .release_o(rel)
  );

  blank_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .tick_o(tick)
  );

  outport_latch #(.W(DW)) u_out (
    .clk(clk), .rst(rst),
    .set_we(bus_wr && bus_addr == OFS_SET),
    .clr_we(bus_wr && bus_addr == OFS_CLR),
    .wdata(bus_wdata), .pins_o(out_pins)
  );

  assign ev_any = |(press | rel);
  assign rd_chg = bus_rd && (bus_addr == OFS_CHG);

  always_comb begin
    chg_n  = chg_q;
    lvl_n  = lvl_q;
    stat_n = stat_q;
    vec_n  = irq_vec;
    if (rd_chg) begin
      chg_n[3:0]       = '0;
      stat_n[STAT_CHG] = 1'b0;
      vec_n            = '0;
    end
    // highest index first so the lowest-numbered button is applied last
    for (int i = NBTN - 1; i >= 0; i--) begin
      if (press[i] || rel[i]) begin
        chg_n             = '0;
        chg_n[chg_bit(i)] = 1'b1;
        lvl_n             = lvl_n | LVL_BTNS;
        if (press[i]) lvl_n[lvl_bit(i)] = 1'b0;
        stat_n[STAT_CHG]  = 1'b1;
        vec_n[VEC_PTR]    = 1'b1;
      end
    end
    if (tick) begin
      chg_n[CHG_BLANK] = 1'b1;
      stat_n[STAT_CHG] = 1'b1;
      vec_n[VEC_PTR]   = 1'b1;
      lvl_n[LVL_BLANK] = 1'b0;
    end
    if (evt_kb_rx)  vec_n[VEC_KB]  = 1'b1;
    if (evt_ser_tx) vec_n[VEC_STX] = 1'b1;
    if (evt_ser_rx) vec_n[VEC_SRX] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chg_q     <= CHG_RST;
      lvl_q     <= LVL_RST;
      stat_q    <= '0;
      irq_vec   <= '0;
      irq_o     <= 1'b0;
      bus_rdata <= '0;
    end else begin
      chg_q   <= chg_n;
      lvl_q   <= lvl_n;
      stat_q  <= stat_n;
      irq_vec <= vec_n;
      irq_o   <= |vec_n;
      if (bus_rd) begin
        case (bus_addr)
          OFS_CHG:  bus_rdata <= chg_q;
          OFS_STAT: bus_rdata <= stat_q;
          OFS_LVL:  bus_rdata <= lvl_q;
          default:  bus_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/inport_irq_chk.sv
module inport_irq_chk (
  input logic       clk,
  input logic       rst,
  input logic       ev_any,
  input logic       tick,
  input logic       evt_kb_rx,
  input logic       evt_ser_tx,
  input logic       evt_ser_rx,
  input logic       bus_rd,
  input logic       bus_wr,
  input logic [5:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic [7:0] chg_q,
  input logic [7:0] stat_q,
  input logic [7:0] irq_vec,
  input logic [7:0] out_pins,
  input logic       irq_o
);
  // R4
  btn_sets_irq_chk: assert property (@(posedge clk) disable iff (rst)
    ev_any |=> (stat_q[7] && irq_vec[1]));

  // R5
  tick_marks_chg_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> (chg_q[6] && stat_q[7] && irq_vec[1]));

  // R6
  ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 6'h13 && !ev_any && !tick && !evt_kb_rx && !evt_ser_tx && !evt_ser_rx)
    |=> (irq_vec == 8'h00 && !stat_q[7] && chg_q[3:0] == 4'h0));

  // R7
  kb_evt_chk: assert property (@(posedge clk) disable iff (rst)
    evt_kb_rx |=> irq_vec[2]);

  // R8
  set_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 6'h3B) |=> ((~out_pins & $past(bus_wdata)) == $past(bus_wdata)));

  // R12
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o == (irq_vec != 8'h00));
endmodule

bind inport_irq inport_irq_chk u_chk (
  .clk(clk), .rst(rst), .ev_any(ev_any), .tick(tick),
  .evt_kb_rx(evt_kb_rx), .evt_ser_tx(evt_ser_tx), .evt_ser_rx(evt_ser_rx),
  .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .chg_q(chg_q), .stat_q(stat_q), .irq_vec(irq_vec), .out_pins(out_pins),
  .irq_o(irq_o)
);

// File: tb/sim_inport_irq.sv
module sim_inport_irq;
  localparam int TDIV = 4000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] btn_n = 3'b111;
  logic       kb = 1'b0, stx = 1'b0, srx = 1'b0;
  logic [5:0] addr = '0;
  logic       rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, pins, vec;
  logic       irq;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;
  logic rd_seen = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  inport_irq #(.TICK_DIV(TDIV)) u0 (
    .clk(clk), .rst(rst), .btn_n_i(btn_n),
    .evt_kb_rx(kb), .evt_ser_tx(stx), .evt_ser_rx(srx),
    .bus_addr(addr), .bus_rd(rd), .bus_wr(wr), .bus_wdata(wdata),
    .bus_rdata(rdata), .out_pins(pins), .irq_vec(vec), .irq_o(irq)
  );

  always @(posedge clk) begin
    rd_seen <= rd;
    cyc <= cyc + 1;
  end

  // monitor: pops the expected read value once the data is out
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        fails++;
        $display("FAIL %s: bus_rdata=%02h expected %02h", t, rdata, e);
      end
    end
  end

  task automatic chk(input string t, input logic [7:0] act, input logic [7:0] e);
    checks++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", t, act, e);
    end
  endtask

  task automatic rd_exp(input logic [5:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    rd = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic wr_reg(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic set_btn(input logic [2:0] v);
    @(negedge clk);
    btn_n = v;
    repeat (6) @(negedge clk);
  endtask

  task automatic summary;
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, got 0 expected 1");
      summary();
    end
  end

  initial begin
    int t0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 pins", pins, 8'hFF);
    chk("R1 vec", vec, 8'h00);
    chk("R12 irq idle", {7'd0, irq}, 8'h00);
    rd_exp(6'h37, 8'h0B, "R1 level");
    rd_exp(6'h17, 8'h00, "R1 status");
    rd_exp(6'h13, 8'h40, "R1 change");

    // R2 press button 0
    set_btn(3'b110);
    chk("R4 vec after press", vec, 8'h02);
    chk("R12 irq after press", {7'd0, irq}, 8'h01);
    rd_exp(6'h17, 8'h80, "R4 status");
    rd_exp(6'h37, 8'h03, "R2 level b0");
    rd_exp(6'h13, 8'h80, "R2 change b0");
    chk("R6 vec cleared", vec, 8'h00);
    chk("R12 irq cleared", {7'd0, irq}, 8'h00);
    rd_exp(6'h17, 8'h00, "R6 status cleared");
    rd_exp(6'h13, 8'h80, "R6 high nibble kept");
    // R3 release button 0
    set_btn(3'b111);
    rd_exp(6'h37, 8'h0B, "R3 level b0");
    rd_exp(6'h13, 8'h80, "R3 change b0");
    // button 1
    set_btn(3'b101);
    rd_exp(6'h37, 8'h09, "R2 level b1");
    rd_exp(6'h13, 8'h20, "R2 change b1");
    set_btn(3'b111);
    rd_exp(6'h37, 8'h0B, "R3 level b1");
    rd_exp(6'h13, 8'h20, "R3 change b1");
    // button 2
    set_btn(3'b011);
    rd_exp(6'h37, 8'h0A, "R2 level b2");
    rd_exp(6'h13, 8'h10, "R2 change b2");
    set_btn(3'b111);
    rd_exp(6'h37, 8'h0B, "R3 level b2");
    rd_exp(6'h13, 8'h10, "R3 change b2");
    // R11 buttons 0 and 2 together
    set_btn(3'b010);
    rd_exp(6'h13, 8'h80, "R11 change pair");
    rd_exp(6'h37, 8'h03, "R11 level pair");
    set_btn(3'b111);
    rd_exp(6'h13, 8'h80, "R11 change pair release");

    // R7 event sources
    @(negedge clk); kb = 1'b1; @(negedge clk); kb = 1'b0;
    chk("R7 kb bit", vec, 8'h04);
    @(negedge clk); stx = 1'b1; @(negedge clk); stx = 1'b0;
    chk("R7 ser tx bit", vec, 8'h14);
    @(negedge clk); srx = 1'b1; @(negedge clk); srx = 1'b0;
    chk("R7 ser rx bit", vec, 8'h34);
    chk("R12 irq events", {7'd0, irq}, 8'h01);
    rd_exp(6'h13, 8'h80, "R7 ack read");
    chk("R7 vec after ack", vec, 8'h00);

    // R10 event in the acknowledging cycle
    @(negedge clk);
    rd = 1'b1; addr = 6'h13; srx = 1'b1;
    exp_q.push_back(8'h80); tag_q.push_back("R10 read old value");
    @(negedge clk);
    rd = 1'b0; srx = 1'b0;
    chk("R10 event survives", vec, 8'h20);
    rd_exp(6'h13, 8'h80, "R10 second ack");
    chk("R10 vec clear", vec, 8'h00);

    // R8 output latch
    wr_reg(6'h3B, 8'h5A);
    chk("R8 set", pins, 8'hA5);
    wr_reg(6'h3B, 8'h81);
    chk("R8 set or", pins, 8'h24);
    wr_reg(6'h3F, 8'h18);
    chk("R8 clear", pins, 8'h3C);
    wr_reg(6'h13, 8'hFF);
    chk("R8 other offset", pins, 8'h3C);
    rd_exp(6'h13, 8'h80, "R8 change untouched");
    // R9 unmapped read
    rd_exp(6'h20, 8'h00, "R9 unmapped");

    // R5 blank tick and its period
    @(posedge irq);
    t0 = cyc;
    @(negedge clk);
    chk("R5 vec on tick", vec, 8'h02);
    rd_exp(6'h17, 8'h80, "R5 status on tick");
    rd_exp(6'h13, 8'hC0, "R5 change on tick");
    rd_exp(6'h37, 8'h0B, "R5 level on tick");
    rd_exp(6'h13, 8'hC0, "R6 bit6 kept");
    @(posedge irq);
    checks++;
    if (cyc - t0 != TDIV) begin
      fails++;
      $display("FAIL R5 period: got %0d expected %0d", cyc - t0, TDIV);
    end
    done = 1;
    summary();
  end
endmodule